// File: doc/BRIEF.md
# Single-Frame Packet Buffer

This block sits between a processor register bus and the data path of a simple Ethernet MAC. It holds at most one outgoing frame and presents at most one incoming frame at a time. Software fills the transmit buffer one 32-bit word at a time through a transmit data port. It starts the frame by writing a length and a go bit to the transmit control register. The block then streams the words to the MAC and keeps the go bit set until the MAC reports completion.

On the receive side the MAC pushes words into the buffer. When the final word arrives, the receive control register shows a ready bit, error flags and the byte length. Software pops the words from a single data address. It then writes zero to the receive control register, which frees the slot for the next frame.

Two interrupts are provided. The receive interrupt is a level output that follows the ready bit. The transmit-done interrupt is a one-cycle pulse at completion. Each interrupt has its own enable bit.

Top module: `frame_slot_buffer`

## Requirements
- R1: After reset, the transmit control, receive control and interrupt enable registers read zero. Both interrupts are low, `mac_tx_valid` is low and `mac_rx_ready` is high.
- R2: A write to the transmit control register (word address 1) with bit 15 set starts a frame whose byte length is taken from bits LEN_W-1:0. The block offers ceil(length/4) words in the order they were written and flags the final word with `mac_tx_last`. In that final word, bytes at positions at or beyond the length read as zero. Bytes are big-endian, so byte 0 is bits 31:24.
- R3: Bit 15 of the transmit control register reads 1 from the commit until the MAC pulses `mac_tx_done`. It then reads 0, and bit 14 shows the `mac_tx_fail` value given with that pulse. The length field keeps its value.
- R4: While bit 15 of the transmit control register is set, writes to the transmit data port (word address 0) and to the transmit control register are ignored. A write to the data port in that time does not change the words being sent.
- R5: When no frame is in flight, a transmit control write with bit 15 clear loads the length field and clears bit 14. Writing zero therefore makes the register read zero.
- R6: When the MAC delivers a word with `mac_rx_last`, the receive control register (word address 3) reads as follows: bit 15 ready, bit 14 general error, bit 13 CRC error, and the byte length in bits LEN_W-1:0. `mac_rx_ready` stays low while the ready bit is set.
- R7: Each read of the receive data port (word address 2) returns the next stored word and advances past it. The final word of the frame has the bytes beyond the length zeroed, big-endian. A read with no stored word left, or with no frame ready, returns zero.
- R8: Writing zero to the receive control register while a frame is ready clears the register, discards any unread words and raises `mac_rx_ready`. Writing a nonzero value has no effect.
- R9: Words that arrive beyond the buffer capacity of DEPTH words are dropped, and the general error bit of the frame is set. The stored words still read back unchanged.
- R10: `irq_rx` is high exactly while the receive ready bit and enable bit 0 are both set.
- R11: `irq_tx` pulses for one cycle, in the cycle after the MAC completion, when enable bit 1 is set at that time. A completion that happens while the bit is clear is not signalled later when the bit is set.
- R12: The interrupt enable register (word address 4, bit 0 receive, bit 1 transmit) reads back what was written. Writing zero masks both interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive data port) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| mac_tx_valid | output | 1 | Transmit word offered to the MAC |
| mac_tx_data | output | 32 | Transmit word |
| mac_tx_last | output | 1 | Final word of the frame |
| mac_tx_ready | input | 1 | MAC accepts the offered word |
| mac_tx_done | input | 1 | MAC finished sending the frame |
| mac_tx_fail | input | 1 | Outcome given with mac_tx_done |
| mac_rx_valid | input | 1 | Received word present |
| mac_rx_data | input | 32 | Received word |
| mac_rx_last | input | 1 | Final word of the received frame |
| mac_rx_len | input | LEN_W | Byte length, valid with mac_rx_last |
| mac_rx_err | input | 1 | General receive error, valid with mac_rx_last |
| mac_rx_crc_bad | input | 1 | CRC error, valid with mac_rx_last |
| mac_rx_ready | output | 1 | Buffer slot free to accept words |
| irq_rx | output | 1 | Receive-ready interrupt (level) |
| irq_tx | output | 1 | Transmit-done interrupt (one-cycle pulse) |

## Verification
A read or write pointer that is off by one appears in the very next bus read or the next word offered to the MAC. It shows as a shifted or repeated word, or as a final word whose tail bytes are not zeroed. A busy or ready flag stuck in the wrong state shows within one cycle at the control register readback, at `mac_rx_ready` or at the interrupt pins. A leftover pointer after a receive acknowledge shows in the first word of the next frame.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
   localparam logic [2:0] ADDR_TXD = 3'd0;
   localparam logic [2:0] ADDR_TXC = 3'd1;
   localparam logic [2:0] ADDR_RXD = 3'd2;
   localparam logic [2:0] ADDR_RXC = 3'd3;
   localparam logic [2:0] ADDR_IEN = 3'd4;

   localparam int GO_BIT   = 15;
   localparam int FAIL_BIT = 14;
   localparam int CRC_BIT  = 13;

   // zero the bytes past the frame end in a big-endian final word
   function automatic logic [31:0] tail_zero(input logic [31:0] w, input logic [1:0] rem);
      logic [31:0] keep;
      keep = ~(32'hFFFF_FFFF >> (8 * rem));
      return (rem == 2'd0) ? w : (w & keep);
   endfunction
endpackage

// File: rtl/fsb_tx.sv
module fsb_tx
   import fsb_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_wr,
   input  logic [31:0]      data_wdata,
   input  logic             ctl_wr,
   input  logic [31:0]      ctl_wdata,
   output logic             busy,
   output logic             fail,
   output logic [LEN_W-1:0] len,
   output logic             done_pulse,
   output logic             mac_tx_valid,
   output logic [31:0]      mac_tx_data,
   output logic             mac_tx_last,
   input  logic             mac_tx_ready,
   input  logic             mac_tx_done,
   input  logic             mac_tx_fail
);
   localparam int IW = $clog2(DEPTH);
   localparam int PW = IW + 1;
   localparam logic [PW-1:0]  DEPTH_P = PW'(DEPTH);
   localparam logic [LEN_W:0] DEPTH_L = (LEN_W + 1)'(DEPTH);

   logic [31:0]      mem [DEPTH];
   logic [PW-1:0]    wptr, sidx, nw;
   logic [LEN_W:0]   nw_full;
   logic             sending;
   logic             wr_ok;
   logic [31:0]      cur;

   always_comb begin
      nw_full = ({1'b0, len} + (LEN_W + 1)'(3)) >> 2;
      nw      = (nw_full > DEPTH_L) ? DEPTH_P : nw_full[PW-1:0];
   end

   assign wr_ok = data_wr && !busy && (wptr < DEPTH_P);

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr[IW-1:0]] <= data_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         fail       <= 1'b0;
         len        <= '0;
         wptr       <= '0;
         sidx       <= '0;
         sending    <= 1'b0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         if (!busy) begin
            if (wr_ok) wptr <= wptr + PW'(1);
            if (ctl_wr) begin
               len  <= ctl_wdata[LEN_W-1:0];
               fail <= 1'b0;
               if (ctl_wdata[GO_BIT]) begin
                  busy    <= 1'b1;
                  wptr    <= '0;
                  sidx    <= '0;
                  sending <= (ctl_wdata[LEN_W-1:0] != '0);
               end
            end
         end else if (sending) begin
            if (mac_tx_ready) begin
               if (mac_tx_last) sending <= 1'b0;
               else             sidx    <= sidx + PW'(1);
            end
         end else if (mac_tx_done) begin
            busy       <= 1'b0;
            fail       <= mac_tx_fail;
            done_pulse <= 1'b1;
         end
      end
   end

   assign cur          = mem[sidx[IW-1:0]];
   assign mac_tx_valid = sending;
   assign mac_tx_last  = sending && (sidx == nw - PW'(1));
   assign mac_tx_data  = mac_tx_last ? tail_zero(cur, len[1:0]) : cur;

   // R2
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mac_tx_valid && !mac_tx_ready) |=> (mac_tx_valid && $stable(mac_tx_data)));
   // R3
   tx_done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (!busy && $past(busy)));
   // R4
   tx_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mac_tx_valid);
endmodule

// File: rtl/fsb_rx.sv
module fsb_rx
   import fsb_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mac_rx_valid,
   input  logic [31:0]      mac_rx_data,
   input  logic             mac_rx_last,
   input  logic [LEN_W-1:0] mac_rx_len,
   input  logic             mac_rx_err,
   input  logic             mac_rx_crc_bad,
   output logic             mac_rx_ready,
   input  logic             ack,
   input  logic             pop,
   output logic [31:0]      rd_word,
   output logic             ready,
   output logic             err,
   output logic             crc,
   output logic [LEN_W-1:0] len
);
   localparam int IW = $clog2(DEPTH);
   localparam int PW = IW + 1;
   localparam logic [PW-1:0]  DEPTH_P = PW'(DEPTH);
   localparam logic [LEN_W:0] DEPTH_L = (LEN_W + 1)'(DEPTH);

   logic [31:0]    mem [DEPTH];
   logic [PW-1:0]  wptr, rptr, nw;
   logic [LEN_W:0] nw_full;
   logic           ovf, accept, room, have;
   logic [31:0]    cur;

   assign mac_rx_ready = !ready;
   assign accept       = mac_rx_valid && !ready;
   assign room         = (wptr < DEPTH_P);
   assign have         = ready && (rptr < wptr);

   always_comb begin
      nw_full = ({1'b0, len} + (LEN_W + 1)'(3)) >> 2;
      nw      = (nw_full > DEPTH_L) ? DEPTH_P : nw_full[PW-1:0];
   end

   always_ff @(posedge clk) begin
      if (accept && room) mem[wptr[IW-1:0]] <= mac_rx_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         ovf   <= 1'b0;
         ready <= 1'b0;
         err   <= 1'b0;
         crc   <= 1'b0;
         len   <= '0;
      end else if (accept) begin
         if (room) wptr <= wptr + PW'(1);
         else      ovf  <= 1'b1;
         if (mac_rx_last) begin
            ready <= 1'b1;
            len   <= mac_rx_len;
            err   <= mac_rx_err || ovf || !room;
            crc   <= mac_rx_crc_bad;
         end
      end else if (ready && ack) begin
         wptr  <= '0;
         rptr  <= '0;
         ovf   <= 1'b0;
         ready <= 1'b0;
         err   <= 1'b0;
         crc   <= 1'b0;
         len   <= '0;
      end else if (pop && have) begin
         rptr <= rptr + PW'(1);
      end
   end

   assign cur     = mem[rptr[IW-1:0]];
   assign rd_word = !have ? 32'h0 :
                    (rptr == nw - PW'(1)) ? tail_zero(cur, len[1:0]) : cur;

   // R6
   rx_ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(mac_rx_valid && mac_rx_last));
   // R7
   rx_ptr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rptr <= wptr);
   // R8
   rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(ack));
   // R9
   rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wptr <= DEPTH_P);
endmodule

// File: rtl/fsb_irq.sv
module fsb_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_wr,
   input  logic [1:0] en_wdata,
   input  logic       rx_ready,
   input  logic       tx_done,
   output logic [1:0] en,
   output logic       irq_rx,
   output logic       irq_tx
);
   always_ff @(posedge clk) begin
      if (!rst_n)     en <= 2'b00;
      else if (en_wr) en <= en_wdata;
   end

   assign irq_rx = rx_ready && en[0];
   assign irq_tx = tx_done && en[1];

   // R11
   irq_tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |=> !irq_tx);
endmodule

// File: rtl/frame_slot_buffer.sv
module frame_slot_buffer
   import fsb_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [2:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             mac_tx_valid,
   output logic [31:0]      mac_tx_data,
   output logic             mac_tx_last,
   input  logic             mac_tx_ready,
   input  logic             mac_tx_done,
   input  logic             mac_tx_fail,
   input  logic             mac_rx_valid,
   input  logic [31:0]      mac_rx_data,
   input  logic             mac_rx_last,
   input  logic [LEN_W-1:0] mac_rx_len,
   input  logic             mac_rx_err,
   input  logic             mac_rx_crc_bad,
   output logic             mac_rx_ready,
   output logic             irq_rx,
   output logic             irq_tx
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LEN_W < $clog2(DEPTH * 4 + 1) || LEN_W > CRC_BIT) begin : g_bad_len
      $error("LEN_W must cover DEPTH*4 bytes and stay below the flag bits");
   end

   logic             tx_busy, tx_fail, tx_done;
   logic [LEN_W-1:0] tx_len, rx_len;
   logic             rx_ready, rx_err, rx_crc;
   logic [31:0]      rx_word;
   logic [1:0]       ien;

   fsb_tx #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .data_wr(bus_wr && bus_addr == ADDR_TXD), .data_wdata(bus_wdata),
      .ctl_wr(bus_wr && bus_addr == ADDR_TXC), .ctl_wdata(bus_wdata),
      .busy(tx_busy), .fail(tx_fail), .len(tx_len), .done_pulse(tx_done),
      .mac_tx_valid(mac_tx_valid), .mac_tx_data(mac_tx_data),
      .mac_tx_last(mac_tx_last), .mac_tx_ready(mac_tx_ready),
      .mac_tx_done(mac_tx_done), .mac_tx_fail(mac_tx_fail)
   );

   fsb_rx #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .mac_rx_valid(mac_rx_valid), .mac_rx_data(mac_rx_data),
      .mac_rx_last(mac_rx_last), .mac_rx_len(mac_rx_len),
      .mac_rx_err(mac_rx_err), .mac_rx_crc_bad(mac_rx_crc_bad),
      .mac_rx_ready(mac_rx_ready),
      .ack(bus_wr && bus_addr == ADDR_RXC && bus_wdata == 32'h0),
      .pop(bus_rd && bus_addr == ADDR_RXD),
      .rd_word(rx_word), .ready(rx_ready), .err(rx_err), .crc(rx_crc), .len(rx_len)
   );

   fsb_irq u_irq (
      .clk(clk), .rst_n(rst_n),
      .en_wr(bus_wr && bus_addr == ADDR_IEN), .en_wdata(bus_wdata[1:0]),
      .rx_ready(rx_ready), .tx_done(tx_done),
      .en(ien), .irq_rx(irq_rx), .irq_tx(irq_tx)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_TXC: begin
            bus_rdata[GO_BIT]      = tx_busy;
            bus_rdata[FAIL_BIT]    = tx_fail;
            bus_rdata[LEN_W-1:0]   = tx_len;
         end
         ADDR_RXD: bus_rdata = rx_word;
         ADDR_RXC: begin
            bus_rdata[GO_BIT]      = rx_ready;
            bus_rdata[FAIL_BIT]    = rx_err;
            bus_rdata[CRC_BIT]     = rx_crc;
            bus_rdata[LEN_W-1:0]   = rx_len;
         end
         ADDR_IEN: bus_rdata[1:0] = ien;
         default: ;
      endcase
   end

   // R11
   irq_tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |-> !tx_busy);
endmodule

// File: tb/frame_slot_buffer_bench.sv
`timescale 1ns/1ps
module frame_slot_buffer_bench;
   localparam int DEPTH = 16;
   localparam int LEN_W = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic mac_tx_valid, mac_tx_last, mac_rx_ready, irq_rx, irq_tx;
   logic [31:0] mac_tx_data;
   logic mac_tx_ready = 1'b0, mac_tx_done = 1'b0, mac_tx_fail = 1'b0;
   logic mac_rx_valid = 1'b0, mac_rx_last = 1'b0, mac_rx_err = 1'b0, mac_rx_crc_bad = 1'b0;
   logic [31:0] mac_rx_data = '0;
   logic [LEN_W-1:0] mac_rx_len = '0;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   frame_slot_buffer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_frame_slot_buffer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .mac_tx_valid(mac_tx_valid), .mac_tx_data(mac_tx_data), .mac_tx_last(mac_tx_last),
      .mac_tx_ready(mac_tx_ready), .mac_tx_done(mac_tx_done), .mac_tx_fail(mac_tx_fail),
      .mac_rx_valid(mac_rx_valid), .mac_rx_data(mac_rx_data), .mac_rx_last(mac_rx_last),
      .mac_rx_len(mac_rx_len), .mac_rx_err(mac_rx_err), .mac_rx_crc_bad(mac_rx_crc_bad),
      .mac_rx_ready(mac_rx_ready), .irq_rx(irq_rx), .irq_tx(irq_tx)
   );

   // {length in bytes, byte seed}
   localparam logic [15:0] TXV [6] = '{16'h0411, 16'h0522, 16'h0733,
                                       16'h0844, 16'h0D55, 16'h1066};

   function automatic logic [31:0] mkword(input logic [7:0] seed, input int i);
      logic [7:0] b;
      b = seed + 8'(4 * i);
      return {b, b + 8'd1, b + 8'd2, b + 8'd3};
   endfunction

   function automatic logic [31:0] expw(input logic [7:0] seed, input int i, input int ln);
      logic [31:0] w;
      w = mkword(seed, i);
      for (int b = 0; b < 4; b++)
         if (4 * i + b >= ln) w[31 - 8 * b -: 8] = 8'h00;
      return w;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic send_rx(input int n, input logic [7:0] seed, input int ln,
                          input logic e, input logic c);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         mac_rx_valid = 1'b1; mac_rx_data = mkword(seed, i);
         mac_rx_last = (i == n - 1); mac_rx_len = LEN_W'(ln);
         mac_rx_err = e; mac_rx_crc_bad = c;
      end
      @(negedge clk);
      mac_rx_valid = 1'b0; mac_rx_last = 1'b0; mac_rx_err = 1'b0; mac_rx_crc_bad = 1'b0;
   endtask

   // stream one frame out with ready held high, compare each word
   task automatic collect(input string req, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [7:0] seed, input int ln, input bit use_w);
      int cnt, nw;
      cnt = 0; nw = (ln + 3) / 4;
      @(negedge clk);
      mac_tx_ready = 1'b1;
      for (int k = 0; k < 40; k++) begin
         #1;
         if (mac_tx_valid) begin
            check(req, mac_tx_data, use_w ? (cnt == 0 ? w0 : w1) : expw(seed, cnt, ln));
            check({req, " last"}, 32'(mac_tx_last), 32'(cnt == nw - 1));
            cnt++;
            if (mac_tx_last) break;
         end
         @(negedge clk);
      end
      @(negedge clk);
      mac_tx_ready = 1'b0;
      check({req, " count"}, cnt, nw);
   endtask

   task automatic finish_tx(input logic f, input logic exp_irq);
      @(negedge clk);
      mac_tx_done = 1'b1; mac_tx_fail = f;
      @(negedge clk);
      mac_tx_done = 1'b0; mac_tx_fail = 1'b0;
      #1 check("R11 irq_tx at completion", 32'(irq_tx), 32'(exp_irq));
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  ln, seed;
      int          nw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd1, d); check("R1 tx ctrl", d, 32'h0);
      rd(3'd3, d); check("R1 rx ctrl", d, 32'h0);
      rd(3'd4, d); check("R1 irq enable", d, 32'h0);
      check("R1 pins", {irq_rx, irq_tx, mac_tx_valid, mac_rx_ready}, 32'b0001);

      // R12 enable readback
      wr(3'd4, 32'h3);
      rd(3'd4, d); check("R12 enable readback", d, 32'h3);

      // R2 R3 table of transmit frames
      for (int e = 0; e < 6; e++) begin
         ln = TXV[e][15:8]; seed = TXV[e][7:0]; nw = (ln + 3) / 4;
         for (int i = 0; i < nw; i++) wr(3'd0, mkword(seed, i));
         wr(3'd1, 32'h8000 | 32'(ln));
         rd(3'd1, d); check("R3 busy after commit", d, 32'h8000 | 32'(ln));
         collect("R2 tx word", 32'h0, 32'h0, seed, ln, 1'b0);
         rd(3'd1, d); check("R3 busy until done", d, 32'h8000 | 32'(ln));
         finish_tx(e[0], 1'b1);
         rd(3'd1, d); check("R3 status after done", d, (32'(e[0]) << 14) | 32'(ln));
      end

      // R4 writes during busy ignored
      wr(3'd0, 32'hAAAA_0001);
      wr(3'd0, 32'hBBBB_0002);
      wr(3'd1, 32'h8008);
      wr(3'd0, 32'hCCCC_0003);
      wr(3'd1, 32'h0);
      rd(3'd1, d); check("R4 ctrl write ignored", d, 32'h8008);
      collect("R4 tx data", 32'hAAAA_0001, 32'hBBBB_0002, 8'h00, 8, 1'b1);
      finish_tx(1'b1, 1'b1);
      rd(3'd1, d); check("R3 fail flag", d, 32'h4008);

      // R5 clear by writing zero
      wr(3'd1, 32'h0);
      rd(3'd1, d); check("R5 cleared", d, 32'h0);

      // R11 masked completion not re-signalled
      wr(3'd4, 32'h1);
      wr(3'd0, 32'h1234_5678);
      wr(3'd1, 32'h8004);
      collect("R2 tx single", 32'h1234_5678, 32'h0, 8'h00, 4, 1'b1);
      finish_tx(1'b0, 1'b0);
      wr(3'd4, 32'h3);
      repeat (3) begin
         @(negedge clk); #1 check("R11 no late irq_tx", 32'(irq_tx), 32'h0);
      end
      rd(3'd1, d); check("R11 status visible", d, 32'h0004);

      // R7 empty read
      rd(3'd2, d); check("R7 empty read", d, 32'h0);

      // R6 R7 R10 receive frame of 10 bytes
      send_rx(3, 8'hC0, 10, 1'b0, 1'b0);
      #1 check("R6 mac_rx_ready low", 32'(mac_rx_ready), 32'h0);
      check("R10 irq_rx high", 32'(irq_rx), 32'h1);
      rd(3'd3, d); check("R6 rx ctrl", d, 32'h800A);
      for (int i = 0; i < 3; i++) begin
         rd(3'd2, d); check("R7 rx word", d, expw(8'hC0, i, 10));
      end
      rd(3'd2, d); check("R7 read past end", d, 32'h0);

      // R8 nonzero write ignored, zero releases
      wr(3'd3, 32'h5);
      rd(3'd3, d); check("R8 nonzero ignored", d, 32'h800A);
      wr(3'd3, 32'h0);
      #1 check("R8 slot free", {irq_rx, mac_rx_ready}, 32'b01);
      rd(3'd3, d); check("R8 rx ctrl cleared", d, 32'h0);

      // R6 R8 error frame, partial read then discard
      send_rx(2, 8'hD0, 8, 1'b1, 1'b1);
      rd(3'd3, d); check("R6 error flags", d, 32'hE008);
      rd(3'd2, d); check("R7 first word", d, mkword(8'hD0, 0));
      wr(3'd3, 32'h0);
      send_rx(1, 8'hE0, 4, 1'b0, 1'b0);
      rd(3'd2, d); check("R8 leftovers discarded", d, mkword(8'hE0, 0));
      wr(3'd3, 32'h0);

      // R12 R10 masking
      wr(3'd4, 32'h0);
      rd(3'd4, d); check("R12 masked readback", d, 32'h0);
      send_rx(1, 8'h70, 3, 1'b0, 1'b0);
      #1 check("R10 irq_rx masked", 32'(irq_rx), 32'h0);
      wr(3'd4, 32'h1);
      #1 check("R10 irq_rx unmasked", 32'(irq_rx), 32'h1);
      rd(3'd2, d); check("R7 3-byte word", d, expw(8'h70, 0, 3));
      wr(3'd3, 32'h0);

      // R9 overflow
      send_rx(DEPTH + 2, 8'hF0, DEPTH * 4, 1'b0, 1'b0);
      rd(3'd3, d); check("R9 overflow error", d, 32'hC000 | 32'(DEPTH * 4));
      rd(3'd2, d); check("R9 stored word", d, mkword(8'hF0, 0));
      wr(3'd3, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule